// File: doc/BRIEF.md
# Temperature-Scaled Refresh Scheduler

This block tells a DRAM command arbiter when a REFRESH is owed. A down-counter measures the average refresh interval for the current case-temperature band. Each time the interval runs out, one more refresh is added to an owed count. The arbiter sees a normal request while anything is owed. It sees an urgent request once the backlog reaches the postponement limit, which keeps every window of nine refreshes inside the maximum spacing. The arbiter answers with a one-cycle acknowledge when it issues the command.

The interval depends on the band. The two-bit band code 0 means at or below 85°C, 1 means above 85°C, 2 means above 105°C and 3 means above 115°C. The interval is the base interval (7.8 µs by default) divided by 1, 2, 4 or 8, converted to clocks with the clock-period parameter and rounded down.

After each issued refresh the block holds off the next REFRESH and any ACTIVATE for the minimum refresh period, converted to clocks and rounded up. When the clock period is longer than 40 ns, two more rules apply: the hold-off is never shorter than two cycles, so at least one idle slot separates two refreshes, and each refresh is followed by a one-cycle request for a precharge of all banks.

Top module: `refresh_sched`

## Requirements
- R1: During and directly after synchronous reset, ref_req, ref_urgent, act_block and pre_all_req are 0 and owed_count is 0.
- R2: With the band held, owed_count rises by one every L(band) clocks, where L(band) = floor((TREFI_BASE_NS >> band) * 1000 / CLK_PERIOD_PS). The first rise comes L(0) clocks after reset is released.
- R3: When the band code rises to a faster rate, the running interval is cut at once to at most the new band's length. When it falls to a slower rate, the running interval completes unchanged and the new length applies from the next reload.
- R4: ref_req is high whenever owed_count is above 0 and no hold-off window is open. An acknowledge sampled while ref_req is high lowers owed_count by one on the next cycle.
- R5: An acknowledge sampled while ref_req is low has no effect on owed_count, ref_req or act_block.
- R6: ref_urgent is high exactly when owed_count is at or above MAX_POSTPONE (default 8).
- R7: owed_count never exceeds MAX_POSTPONE+1. An interval that expires at that level is not counted.
- R8: After an accepted acknowledge, ref_req is low and act_block is high for G-1 cycles, where G = ceil(TRFC_NS*1000/CLK_PERIOD_PS). G is at least 2 when CLK_PERIOD_PS exceeds SLOW_LIMIT_PS.
- R9: When CLK_PERIOD_PS exceeds SLOW_LIMIT_PS, pre_all_req is high for exactly the one cycle after each accepted acknowledge. Otherwise it stays 0.
- R10: If an interval expires in the same cycle as an accepted acknowledge, owed_count is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_band | input | 2 | Temperature band code: 0 for at or below 85°C, 1 above 85°C, 2 above 105°C, 3 above 115°C |
| ref_ack | input | 1 | Arbiter issued a REFRESH this cycle |
| ref_req | output | 1 | A refresh is owed and may be issued now |
| ref_urgent | output | 1 | The backlog has reached the postponement limit |
| act_block | output | 1 | The minimum refresh period is running; no ACTIVATE or REFRESH allowed |
| pre_all_req | output | 1 | Slow-clock mode: precharge all banks now |
| owed_count | output | clog2(MAX_POSTPONE+2) | Number of refreshes owed |

## Verification
The first pattern holds the band and never acknowledges. It shows the exact interval length for one band and shows where the backlog saturates and the urgent flag rises. The second pattern holds the acknowledge high for a long stretch. It drains the backlog against the hold-off window and shows that an acknowledge arriving while the request is low is ignored. Two directed band steps, one to a faster rate and one back to a slower rate, separate the immediate cut from the deferred reload. A long run with pseudo-random bands and sparse acknowledges drives a fast-clock and a slow-clock build side by side. It exposes same-cycle expiry and acknowledge, and it checks the precharge pulse that only the slow build produces.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

  localparam int unsigned NUM_BANDS = 4;

  // Nanoseconds to clocks, rounded down (for maximum limits such as intervals).
  function automatic int unsigned ns_to_clk_floor(input int unsigned ns,
                                                  input int unsigned period_ps);
    return (ns * 1000) / period_ps;
  endfunction

  // Nanoseconds to clocks, rounded up (for minimum limits).
  function automatic int unsigned ns_to_clk_ceil(input int unsigned ns,
                                                 input int unsigned period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  // Hold-off length after a refresh, including the slow-clock floor of two.
  function automatic int unsigned holdoff_cycles(input int unsigned trfc_ns,
                                                 input int unsigned period_ps,
                                                 input int unsigned slow_ps);
    int unsigned g;
    g = ns_to_clk_ceil(trfc_ns, period_ps);
    if (period_ps > slow_ps && g < 2) g = 2;
    if (g < 1) g = 1;
    return g;
  endfunction

endpackage

// File: rtl/refresh_refi_timer.sv
module refresh_refi_timer
  import refresh_sched_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 20000,
  parameter int unsigned TREFI_BASE_NS = 7800
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] band,
  output logic       tick
);

  localparam int unsigned LEN0     = ns_to_clk_floor(TREFI_BASE_NS, CLK_PERIOD_PS);
  localparam int unsigned LEN0_SAT = (LEN0 > 1) ? LEN0 : 1;
  localparam int unsigned CNT_W    = (LEN0_SAT > 1) ? $clog2(LEN0_SAT) : 1;

  logic [CNT_W-1:0] reload [NUM_BANDS];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] sel;

  // One reload value per band, each half of the previous rate's interval.
  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_reload
    localparam int unsigned LEN  = ns_to_clk_floor(TREFI_BASE_NS >> b, CLK_PERIOD_PS);
    localparam int unsigned LENS = (LEN > 1) ? LEN : 1;
    assign reload[b] = CNT_W'(LENS - 1);
  end

  assign sel  = reload[band];
  assign tick = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= reload[0];
    end else if (tick) begin
      cnt_q <= sel;
    end else if (cnt_q > sel) begin
      // Faster band: cut the running interval now.
      cnt_q <= sel;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/refresh_owed_tracker.sv
module refresh_owed_tracker #(
  parameter int unsigned MAX_POSTPONE = 8,
  parameter int unsigned OWED_W       = $clog2(MAX_POSTPONE + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              take,
  output logic [OWED_W-1:0] owed_q,
  output logic [OWED_W-1:0] owed_d
);

  localparam logic [OWED_W-1:0] CAP = OWED_W'(MAX_POSTPONE + 1);

  always_comb begin
    owed_d = owed_q;
    unique case ({tick, take})
      2'b10: if (owed_q != CAP) owed_d = owed_q + 1'b1;
      2'b01: owed_d = owed_q - 1'b1;
      default: owed_d = owed_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) owed_q <= '0;
    else     owed_q <= owed_d;
  end

endmodule

// File: rtl/refresh_spacing_guard.sv
module refresh_spacing_guard #(
  parameter int unsigned GAP_CYC = 6,
  parameter bit          SLOW    = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  output logic open_d,
  output logic pre_d
);

  if (GAP_CYC > 1) begin : g_gap
    localparam int unsigned GW = (GAP_CYC > 2) ? $clog2(GAP_CYC) : 1;
    logic [GW-1:0] gap_q, gap_d;

    always_comb begin
      if (take)              gap_d = GW'(GAP_CYC - 1);
      else if (gap_q != '0)  gap_d = gap_q - 1'b1;
      else                   gap_d = '0;
    end

    always_ff @(posedge clk) begin
      if (rst) gap_q <= '0;
      else     gap_q <= gap_d;
    end

    assign open_d = (gap_d == '0);
  end else begin : g_nogap
    assign open_d = 1'b1;
  end

  if (SLOW) begin : g_slow
    assign pre_d = take;
  end else begin : g_fast
    logic unused_take;
    assign unused_take = take;
    assign pre_d = 1'b0;
  end

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 20000,
  parameter int unsigned TREFI_BASE_NS = 7800,
  parameter int unsigned TRFC_NS       = 110,
  parameter int unsigned SLOW_LIMIT_PS = 40000,
  parameter int unsigned MAX_POSTPONE  = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [1:0]                          temp_band,
  input  logic                                ref_ack,
  output logic                                ref_req,
  output logic                                ref_urgent,
  output logic                                act_block,
  output logic                                pre_all_req,
  output logic [$clog2(MAX_POSTPONE+2)-1:0]   owed_count
);

  localparam int unsigned OWED_W  = $clog2(MAX_POSTPONE + 2);
  localparam bit          SLOW    = (CLK_PERIOD_PS > SLOW_LIMIT_PS);
  localparam int unsigned GAP_CYC = holdoff_cycles(TRFC_NS, CLK_PERIOD_PS, SLOW_LIMIT_PS);

  logic              tick;
  logic              take;
  logic              open_d;
  logic              pre_d;
  logic [OWED_W-1:0] owed_q, owed_d;

  // Only a request the arbiter could see is consumed.
  assign take = ref_ack & ref_req;

  refresh_refi_timer #(
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .TREFI_BASE_NS (TREFI_BASE_NS)
  ) u_timer (
    .clk  (clk),
    .rst  (rst),
    .band (temp_band),
    .tick (tick)
  );

  refresh_owed_tracker #(
    .MAX_POSTPONE (MAX_POSTPONE),
    .OWED_W       (OWED_W)
  ) u_owed (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .take   (take),
    .owed_q (owed_q),
    .owed_d (owed_d)
  );

  refresh_spacing_guard #(
    .GAP_CYC (GAP_CYC),
    .SLOW    (SLOW)
  ) u_guard (
    .clk    (clk),
    .rst    (rst),
    .take   (take),
    .open_d (open_d),
    .pre_d  (pre_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_req     <= 1'b0;
      ref_urgent  <= 1'b0;
      act_block   <= 1'b0;
      pre_all_req <= 1'b0;
    end else begin
      ref_req     <= (owed_d != '0) && open_d;
      ref_urgent  <= (owed_d >= OWED_W'(MAX_POSTPONE));
      act_block   <= !open_d;
      pre_all_req <= pre_d;
    end
  end

  assign owed_count = owed_q;

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk
  import refresh_sched_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 20000,
  parameter int unsigned TRFC_NS       = 110,
  parameter int unsigned SLOW_LIMIT_PS = 40000,
  parameter int unsigned MAX_POSTPONE  = 8
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              ref_ack,
  input logic                              ref_req,
  input logic                              ref_urgent,
  input logic                              act_block,
  input logic                              pre_all_req,
  input logic [$clog2(MAX_POSTPONE+2)-1:0] owed_count
);

  localparam bit          SLOW    = (CLK_PERIOD_PS > SLOW_LIMIT_PS);
  localparam int unsigned GAP_CYC = holdoff_cycles(TRFC_NS, CLK_PERIOD_PS, SLOW_LIMIT_PS);

  assert_urgent_level_R6: assert property (@(posedge clk) disable iff (rst)
    ref_urgent == (int'(owed_count) >= int'(MAX_POSTPONE)));

  assert_owed_cap_R7: assert property (@(posedge clk) disable iff (rst)
    int'(owed_count) <= int'(MAX_POSTPONE) + 1);

  assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
    int'(owed_count) <= int'($past(owed_count)) + 1);

  assert_ignored_ack_R5: assert property (@(posedge clk) disable iff (rst)
    (ref_ack && !ref_req) |=> (int'(owed_count) >= int'($past(owed_count))));

  assert_req_needs_owed_R4: assert property (@(posedge clk) disable iff (rst)
    ref_req |-> (owed_count != '0));

  assert_block_excludes_req_R8: assert property (@(posedge clk) disable iff (rst)
    act_block |-> !ref_req);

  if (GAP_CYC > 1) begin : g_gap_chk
    assert_holdoff_starts_R8: assert property (@(posedge clk) disable iff (rst)
      (ref_ack && ref_req) |=> (act_block && !ref_req));
  end

  if (SLOW) begin : g_slow_chk
    assert_pre_follows_ack_R9: assert property (@(posedge clk) disable iff (rst)
      pre_all_req |-> $past(ref_ack && ref_req));
  end else begin : g_fast_chk
    assert_no_pre_fast_R9: assert property (@(posedge clk) disable iff (rst)
      !pre_all_req);
  end

endmodule

bind refresh_sched refresh_sched_chk #(
  .CLK_PERIOD_PS (CLK_PERIOD_PS),
  .TRFC_NS       (TRFC_NS),
  .SLOW_LIMIT_PS (SLOW_LIMIT_PS),
  .MAX_POSTPONE  (MAX_POSTPONE)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ref_ack     (ref_ack),
  .ref_req     (ref_req),
  .ref_urgent  (ref_urgent),
  .act_block   (act_block),
  .pre_all_req (pre_all_req),
  .owed_count  (owed_count)
);

// File: tb/refresh_sched_test.sv
`timescale 1ns/1ps
module refresh_sched_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] band = 2'd0;
  logic       ack = 1'b0;

  logic       req [2];
  logic       urg [2];
  logic       blk [2];
  logic       pre [2];
  logic [3:0] owd [2];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit started = 1'b0;
  int cyc = 0;

  // Reference model state, per build (0 = 20 ns build, 1 = 100 ns build).
  int LEN [2][4];
  int GAPC [2];
  bit SLOWF [2];
  int m_cnt [2];
  int m_owed [2];
  int m_gap [2];
  bit m_req [2];
  bit m_urg [2];
  bit m_blk [2];
  bit m_pre [2];

  always #10 clk = ~clk;

  refresh_sched uut (
    .clk(clk), .rst(rst), .temp_band(band), .ref_ack(ack),
    .ref_req(req[0]), .ref_urgent(urg[0]), .act_block(blk[0]),
    .pre_all_req(pre[0]), .owed_count(owd[0]));

  refresh_sched #(.CLK_PERIOD_PS(100000)) uut_slow (
    .clk(clk), .rst(rst), .temp_band(band), .ref_ack(ack),
    .ref_req(req[1]), .ref_urgent(urg[1]), .act_block(blk[1]),
    .pre_all_req(pre[1]), .owed_count(owd[1]));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      int per;
      per = (i == 0) ? 20000 : 100000;
      for (int b = 0; b < 4; b++) LEN[i][b] = ((7800 >> b) * 1000) / per;
      GAPC[i]  = (110000 + per - 1) / per;
      SLOWF[i] = (per > 40000);
      if (SLOWF[i] && GAPC[i] < 2) GAPC[i] = 2;
    end
  end

  // Behavioural reference: one step per clock edge.
  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      int lb;
      bit acc;
      bit tk;
      if (rst) begin
        m_cnt[i] = LEN[i][0] - 1;
        m_owed[i] = 0; m_gap[i] = 0;
        m_req[i] = 0; m_urg[i] = 0; m_blk[i] = 0; m_pre[i] = 0;
      end else begin
        acc = ack && m_req[i];
        tk  = (m_cnt[i] == 0);
        lb  = LEN[i][band] - 1;
        if (tk) m_cnt[i] = lb;
        else if (m_cnt[i] > lb) m_cnt[i] = lb;
        else m_cnt[i] = m_cnt[i] - 1;
        m_owed[i] = m_owed[i] + (tk ? 1 : 0) - (acc ? 1 : 0);
        if (m_owed[i] > 9) m_owed[i] = 9;
        if (acc) m_gap[i] = GAPC[i] - 1;
        else if (m_gap[i] > 0) m_gap[i] = m_gap[i] - 1;
        m_req[i] = (m_owed[i] > 0) && (m_gap[i] == 0);
        m_urg[i] = (m_owed[i] >= 8);
        m_blk[i] = (m_gap[i] != 0);
        m_pre[i] = SLOWF[i] && acc;
      end
    end
    started = 1'b1;
    cyc++;
  end

  // Every-clock comparison, away from the active edge.
  always @(negedge clk) begin
    if (started && !done) begin
      for (int i = 0; i < 2; i++) begin
        check(int'(owd[i]) == m_owed[i], "R2/R3/R7/R10 owed_count", owd[i], m_owed[i]);
        check(req[i] == m_req[i], "R4/R5 ref_req", req[i], m_req[i]);
        check(urg[i] == m_urg[i], "R6 ref_urgent", urg[i], m_urg[i]);
        check(blk[i] == m_blk[i], "R8 act_block", blk[i], m_blk[i]);
        check(pre[i] == m_pre[i], "R9 pre_all_req", pre[i], m_pre[i]);
      end
    end
  end

  // Watchdog.
  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      check(owd[i] == 0 && !req[i] && !urg[i] && !blk[i] && !pre[i],
            "R1 reset state", {owd[i], req[i], urg[i], blk[i], pre[i]}, 0);
    end
    rst = 1'b0;
    // R2: first interval of band 0.
    n = 0;
    do begin @(negedge clk); n++; end while (owd[0] == 0 && n < 1000);
    check(n == LEN[0][0], "R2 first interval clocks", n, LEN[0][0]);
    // R6/R7: let the backlog fill and saturate.
    repeat (9 * LEN[0][0]) @(negedge clk);
    check(owd[0] == 9, "R7 saturated backlog", owd[0], 9);
    check(urg[0] == 1'b1, "R6 urgent at limit", urg[0], 1);
    // R4/R5/R8: hold acknowledge high, drain against the hold-off.
    ack = 1'b1;
    repeat (80) @(negedge clk);
    check(owd[0] == 0, "R4 backlog drained", owd[0], 0);
    ack = 1'b0;
    // R3: faster step cuts the interval; slower step waits for reload.
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (100) @(negedge clk);
    band = 2'd3;
    n = 0;
    do begin @(negedge clk); n++; end while (owd[0] == 0 && n < 1000);
    check(n == LEN[0][3] + 1, "R3 faster band immediate", n, LEN[0][3] + 1);
    band = 2'd0;
    n = 0;
    do begin @(negedge clk); n++; end while (owd[0] < 2 && n < 1000);
    check(n == LEN[0][3], "R3 slower band deferred", n, LEN[0][3]);
    // Mixed run: random bands, sparse acknowledges.
    for (int k = 0; k < 20000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[7:0] == 8'h5A) band = lfsr[9:8];
      ack = (lfsr[3:0] < 4'd3);
      @(negedge clk);
    end
    ack = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule